// File: doc/BRIEF.md
# Rank Interleave Decoder

This block turns an address local to one memory channel into the position of that data inside the channel's DIMMs: which DIMM holds it, which rank on that DIMM, the channel-wide rank number, and the address inside that rank. It holds a small table of address ranges. Each range is split across a power-of-two number of ways. Each way has its own entry that names a channel rank and an offset to remove. The tables are filled through a simple write port before lookups start.

A lookup arrives on a valid/ready request channel with the address and a closed-page flag. The flag picks the interleave granularity. The result leaves on a valid/ready response channel one cycle after acceptance. The response carries a fail flag for addresses that fall in no enabled range. A response that is not taken is held, and it blocks the request side. Mapping the rank address onto DRAM row, column and bank lines is left to a later stage.

Top module: `rank_ilv_decoder`

## Requirements
- R1: A range entry is written with `cfg_sel`=0 at index `cfg_idx[1:0]`. Bit 31 enables the entry. Its upper bound is data bits 11:1 placed at address bit 29 and up, with address bits 28:0 all ones.
- R2: Ranges are scanned from index 0 upward. The lower bound of range i is the upper bound of range i-1, with no +1 added, and this holds even when range i-1 is disabled. Range 0 starts at 0. A range matches when it is enabled and lower bound <= address <= upper bound. When several ranges match, the lowest index wins.
- R3: The way count of a range is 2 raised to data bits 29:28 of its entry, so 1, 2, 4 or 8.
- R4: The interleave shift is 6 when `req_closed_page` is 1 and 13 when it is 0.
- R5: With q = address >> shift, the way is q mod ways. The pre-offset rank address is ((q / ways) << shift) with the low shift bits of the address kept.
- R6: An interleave entry is written with `cfg_sel`=1 at index `cfg_idx` = range*8 + way. Data bits 15:2, shifted left by 26, form an offset. That offset is subtracted, modulo 2^40, from the pre-offset rank address to give `out_rank_addr`. Data bits 19:16 give `out_chan_rank`.
- R7: `out_dimm` is the channel rank divided by 4, and `out_rank` is the channel rank mod 4.
- R8: When no range matches, the response has `out_fail`=1. In that case `out_dimm`, `out_rank`, `out_chan_rank` and `out_rank_addr` keep the values they had before.
- R9: A request is taken when `req_valid` and `req_ready` are both 1. Its response is valid in the next cycle. The response stays valid and stable while `out_ready` is 0. `req_ready` is 1 exactly when no response is pending or the pending one is being taken.
- R10: After reset, `out_valid` is 0 and all result outputs are 0. Every table entry is cleared, so every lookup fails until entries are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | 0 selects the range table, 1 selects the interleave table |
| cfg_idx | input | 5 | Entry index (range: bits 1:0; interleave: range*8+way) |
| cfg_data | input | 32 | Entry word |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_addr | input | 40 | Channel-local address |
| req_closed_page | input | 1 | Channel runs closed-page policy |
| out_valid | output | 1 | Response valid |
| out_ready | input | 1 | Response taken by consumer |
| out_fail | output | 1 | No enabled range covered the address |
| out_dimm | output | 2 | DIMM number |
| out_rank | output | 2 | Rank within the DIMM |
| out_chan_rank | output | 4 | Channel-wide rank number |
| out_rank_addr | output | 40 | Address within the rank |

## Verification
A corrupted range entry or a broken lower-bound chain shows up as a wrong fail flag, or as the wrong way entry, on the very response to an address at a range edge. For this reason the vectors sit on both sides of each bound, including one just past a disabled range and one that two ranges share. A wrong shift or way count gives a wrong rank address and channel rank in that same response, so vectors cover both page policies and three way counts. A response register that moves while the consumer stalls appears within one cycle of the stall, and a fail that overwrites the result appears on the next good comparison.

// File: rtl/rid_pkg.sv
package rid_pkg;
  localparam int ENTRY_W      = 32;
  localparam int LIMIT_LSB    = 29;
  localparam int OFFSET_LSB   = 26;
  localparam int CLOSED_SHIFT = 6;
  localparam int OPEN_SHIFT   = 13;
  localparam int CRANK_W      = 4;
  localparam int OFFS_W       = 14;
  localparam int LIMF_W       = 11;

  typedef struct packed {
    logic              en;
    logic [LIMF_W-1:0] lim_f;
    logic [1:0]        ways_log;
  } range_t;

  typedef struct packed {
    logic [CRANK_W-1:0] crank;
    logic [OFFS_W-1:0]  offs_f;
  } ilv_t;
endpackage

// File: rtl/rid_range_table.sv
module rid_range_table
  import rid_pkg::*;
#(
  parameter int N_RANGE = 4,
  parameter int ADDR_W  = 40,
  localparam int RIDX_W = $clog2(N_RANGE)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [RIDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit,
  output logic [RIDX_W-1:0]   hit_idx,
  output logic [1:0]          hit_ways_log
);
  localparam logic [ADDR_W-1:0] LOW_ONES = (ADDR_W'(1) << LIMIT_LSB) - ADDR_W'(1);

  range_t            ent   [N_RANGE];
  logic [ADDR_W-1:0] upper [N_RANGE];
  logic [N_RANGE-1:0] match;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{wr_data[30], wr_data[27:12], wr_data[0]};

  for (genvar i = 0; i < N_RANGE; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) ent[i] <= '0;
      else if (wr_en && wr_idx == RIDX_W'(i))
        ent[i] <= '{en: wr_data[31], lim_f: wr_data[11:1], ways_log: wr_data[29:28]};
    end

    assign upper[i] = (ADDR_W'(ent[i].lim_f) << LIMIT_LSB) | LOW_ONES;

    if (i == 0) begin : g_first
      assign match[i] = ent[i].en && (addr <= upper[i]);
    end else begin : g_rest
      assign match[i] = ent[i].en && (upper[i-1] <= addr) && (addr <= upper[i]);
    end
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N_RANGE - 1; i >= 0; i--)
      if (match[i]) hit_idx = RIDX_W'(i);
  end

  assign hit          = |match;
  assign hit_ways_log = ent[hit_idx].ways_log;
endmodule

// File: rtl/rid_way_split.sv
module rid_way_split
  import rid_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int WAY_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              closed_page,
  input  logic [1:0]        ways_log,
  output logic [ADDR_W-1:0] pre_addr,
  output logic [WAY_W-1:0]  way_idx
);
  logic [4:0]        shift;
  logic [ADDR_W-1:0] q;
  logic [ADDR_W-1:0] low_mask;
  logic [WAY_W:0]    way_mask;

  always_comb begin
    shift    = closed_page ? 5'(CLOSED_SHIFT) : 5'(OPEN_SHIFT);
    q        = addr >> shift;
    low_mask = (ADDR_W'(1) << shift) - ADDR_W'(1);
    way_mask = ((WAY_W+1)'(1) << ways_log) - (WAY_W+1)'(1);
    way_idx  = q[WAY_W-1:0] & way_mask[WAY_W-1:0];
    pre_addr = ((q >> ways_log) << shift) | (addr & low_mask);
  end
endmodule

// File: rtl/rid_ilv_table.sv
module rid_ilv_table
  import rid_pkg::*;
#(
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output ilv_t               rd_ent
);
  ilv_t mem [DEPTH];

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{wr_data[31:20], wr_data[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= '{crank: wr_data[19:16], offs_f: wr_data[15:2]};
    end
  end

  assign rd_ent = mem[rd_idx];
endmodule

// File: rtl/rank_ilv_decoder.sv
module rank_ilv_decoder
  import rid_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int N_RANGE = 4,
  parameter int N_WAY   = 8,
  localparam int RIDX_W = $clog2(N_RANGE),
  localparam int WAY_W  = $clog2(N_WAY),
  localparam int CIDX_W = RIDX_W + WAY_W,
  localparam int DIMM_W = CRANK_W - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [CIDX_W-1:0]  cfg_idx,
  input  logic [ENTRY_W-1:0] cfg_data,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_closed_page,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_fail,
  output logic [DIMM_W-1:0]  out_dimm,
  output logic [1:0]         out_rank,
  output logic [CRANK_W-1:0] out_chan_rank,
  output logic [ADDR_W-1:0]  out_rank_addr
);
  logic              hit;
  logic [RIDX_W-1:0] hit_idx;
  logic [1:0]        ways_log;
  logic [ADDR_W-1:0] pre_addr;
  logic [WAY_W-1:0]  way_idx;
  ilv_t              ilv;
  logic              accept;
  logic [ADDR_W-1:0] offset;

  rid_range_table #(.N_RANGE(N_RANGE), .ADDR_W(ADDR_W)) u_ranges (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we && !cfg_sel), .wr_idx(cfg_idx[RIDX_W-1:0]), .wr_data(cfg_data),
    .addr(req_addr), .hit(hit), .hit_idx(hit_idx), .hit_ways_log(ways_log)
  );

  rid_way_split #(.ADDR_W(ADDR_W), .WAY_W(WAY_W)) u_split (
    .addr(req_addr), .closed_page(req_closed_page), .ways_log(ways_log),
    .pre_addr(pre_addr), .way_idx(way_idx)
  );

  rid_ilv_table #(.DEPTH(N_RANGE * N_WAY)) u_ilv (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we && cfg_sel), .wr_idx(cfg_idx), .wr_data(cfg_data),
    .rd_idx({hit_idx, way_idx}), .rd_ent(ilv)
  );

  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;
  assign offset    = ADDR_W'(ilv.offs_f) << OFFSET_LSB;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_fail      <= 1'b0;
      out_dimm      <= '0;
      out_rank      <= '0;
      out_chan_rank <= '0;
      out_rank_addr <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_fail  <= !hit;
      if (hit) begin
        out_chan_rank <= ilv.crank;
        out_dimm      <= ilv.crank[CRANK_W-1:2];
        out_rank      <= ilv.crank[1:0];
        out_rank_addr <= pre_addr - offset;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rank_addr)
                               && $stable(out_chan_rank) && $stable(out_fail))
    else $error("response changed while stalled");

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid)
    else $error("response missing after accept");

  assert_fail_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit |=> out_fail && $stable(out_rank_addr) && $stable(out_chan_rank)
                       && $stable(out_dimm) && $stable(out_rank))
    else $error("fail altered result outputs");

  assert_split_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_dimm == out_chan_rank[CRANK_W-1:2] && out_rank == out_chan_rank[1:0])
    else $error("dimm/rank disagree with channel rank");
endmodule

// File: tb/rank_ilv_decoder_bench.sv
module rank_ilv_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic        req_valid = 1'b0, req_closed_page = 1'b0, out_ready = 1'b1;
  logic [39:0] req_addr = '0;
  logic        req_ready, out_valid, out_fail;
  logic [1:0]  out_dimm, out_rank;
  logic [3:0]  out_chan_rank;
  logic [39:0] out_rank_addr;

  int errors = 0, checks = 0, cycles = 0;

  always #10 clk = ~clk;

  rank_ilv_decoder u_rank_ilv_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_closed_page(req_closed_page), .out_valid(out_valid), .out_ready(out_ready),
    .out_fail(out_fail), .out_dimm(out_dimm), .out_rank(out_rank),
    .out_chan_rank(out_chan_rank), .out_rank_addr(out_rank_addr)
  );

  typedef struct packed {
    logic [39:0] addr;
    logic        closed;
    logic        fail;
    logic [3:0]  cr;
    logic [39:0] ra;
  } vec_t;

  // Ranges: 0 en ub 0x3FFFFFFF 1 way; 1 disabled ub 0x5FFFFFFF; 2 en ub 0x9FFFFFFF 2 ways;
  // 3 en ub 0x11FFFFFFF 8 ways. Fail rows carry the previous result (R8).
  localparam vec_t VECS [10] = '{
    '{40'h00_0000_1234, 1'b0, 1'b0, 4'd5,  40'h00_0000_1234},
    '{40'h00_3FFF_FFFF, 1'b1, 1'b0, 4'd5,  40'h00_3FFF_FFFF},
    '{40'h00_4000_0000, 1'b0, 1'b1, 4'd5,  40'h00_3FFF_FFFF},
    '{40'h00_5FFF_FFFF, 1'b0, 1'b0, 4'd9,  40'h00_27FF_FFFF},
    '{40'h00_6000_0040, 1'b1, 1'b0, 4'd9,  40'h00_2800_0000},
    '{40'h00_6000_0000, 1'b1, 1'b0, 4'd2,  40'h00_2C00_0000},
    '{40'h00_9FFF_FFFF, 1'b0, 1'b0, 4'd9,  40'h00_47FF_FFFF},
    '{40'h00_A000_A000, 1'b0, 1'b0, 4'd13, 40'h00_1400_0000},
    '{40'h01_2000_0000, 1'b0, 1'b1, 4'd13, 40'h00_1400_0000},
    '{40'h00_A000_01C7, 1'b1, 1'b0, 4'd15, 40'h00_1400_0007}
  };

  task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [39:0] a, input logic closed);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_closed_page = closed;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_result(input string tag, input logic fail, input logic [3:0] cr, input logic [39:0] ra);
    check(out_valid == 1'b1, {tag, " R9 valid"}, 40'(out_valid), 40'd1);
    check(out_fail == fail, {tag, " R8 fail flag"}, 40'(out_fail), 40'(fail));
    check(out_chan_rank == cr, {tag, " R6 chan rank"}, 40'(out_chan_rank), 40'(cr));
    check(out_dimm == cr[3:2] && out_rank == cr[1:0], {tag, " R7 dimm/rank"},
          40'({out_dimm, out_rank}), 40'(cr));
    check(out_rank_addr == ra, {tag, " R5 R6 rank addr"}, out_rank_addr, ra);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0 && req_ready == 1'b1, "R10 reset handshake", 40'({out_valid, req_ready}), 40'd1);
    check(out_rank_addr == '0 && out_chan_rank == '0, "R10 reset outputs", out_rank_addr, 40'd0);
    // R10: empty tables fail every lookup
    lookup(40'h0000_0100, 1'b0);
    check_result("R10 empty table", 1'b1, 4'd0, 40'd0);

    // R1 R3: range entries
    cfg_write(1'b0, 5'd0, 32'h8000_0002);
    cfg_write(1'b0, 5'd1, 32'h0000_0004);
    cfg_write(1'b0, 5'd2, 32'h9000_0008);
    cfg_write(1'b0, 5'd3, 32'hB000_0010);
    // R6: interleave entries, index range*8+way
    cfg_write(1'b1, 5'd0,  32'h0005_0000);
    cfg_write(1'b1, 5'd16, 32'h0002_0004);
    cfg_write(1'b1, 5'd17, 32'h0009_0008);
    for (int w = 0; w < 8; w++) cfg_write(1'b1, 5'(24 + w), 32'((8 + w) << 16));

    // Vector walk covering R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 10; i++) begin
      lookup(VECS[i].addr, VECS[i].closed);
      check_result($sformatf("vec%0d R1 R2 R3 R4", i), VECS[i].fail, VECS[i].cr, VECS[i].ra);
    end

    // R9: back-pressure holds the response and blocks requests
    @(negedge clk);
    out_ready = 1'b0; req_valid = 1'b1; req_addr = 40'h0000_1234; req_closed_page = 1'b0;
    @(negedge clk);
    req_addr = 40'h00_A000_A000;
    for (int k = 0; k < 3; k++) begin
      check(req_ready == 1'b0, "R9 ready low while stalled", 40'(req_ready), 40'd0);
      check(out_valid && out_rank_addr == 40'h1234 && out_chan_rank == 4'd5,
            "R9 held response", out_rank_addr, 40'h1234);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_result("R9 handover", 1'b0, 4'd13, 40'h00_1400_0000);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 drained", 40'(out_valid), 40'd0);

    // R6: rewritten entry with offset; R7 rank 3 on dimm 0
    cfg_write(1'b1, 5'd0, 32'h0003_0004);
    lookup(40'h0000_0800_0000, 1'b0);
    check_result("R6 rewrite", 1'b0, 4'd3, 40'h0000_0400_0000);
    // R2: disabling range 0 moves addresses below it to fail
    cfg_write(1'b0, 5'd0, 32'h0000_0002);
    lookup(40'h0000_0000_0040, 1'b1);
    check_result("R2 disabled range", 1'b1, 4'd3, 40'h0000_0400_0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule